// File: doc/BRIEF.md
# Multi-Source Reset Sequencer

This block gathers reset requests from six causes and turns them into one orderly reset of the chip. The six causes are power-on, the external reset pin, a watchdog timeout, a low-voltage detect, an illegal opcode and an illegal address. It drives an internal reset to the rest of the chip. For causes raised inside the chip, it also pulls the shared bidirectional reset pin low for a fixed window, so that parts on the board are reset along with the chip. Once the pin is released, it holds the internal reset for a second window. Power-on and low-voltage resets first wait through a long stabilisation window.

A free-running system counter runs beside the sequencer. Every internally raised reset clears it, but a reset from the pin leaves it running. A six-bit cause register records which causes have fired since it was last read, and a read strobe clears it. The block also presents the address pair of the reset vector, which moves to a different page while monitor mode is active. The pin acts as a reset input only when a configuration enable is set. A pin-cause bit is recorded only when the pin stays low for a minimum number of cycles.

Top module: `reset_sequencer`

## Requirements
- R1: While `por_i` is high and right after it, `status_o` is 6'b000001 and `sys_cnt_o` is 0. The cause bits are: bit0 power-on, bit1 pin, bit2 watchdog, bit3 low-voltage, bit4 illegal opcode, bit5 illegal address. `irst_o` stays high through STAB_CYC (4096) cycles without pin drive, then DRV_CYC (32) cycles with pin drive, then HOLD_CYC (32) cycles.
- R2: `vec_hi_addr_o`/`vec_lo_addr_o` read 16'hFFFE/16'hFFFF when `monitor_i` is low and 16'hFEFE/16'hFEFF when it is high.
- R3: `sys_cnt_o` rises by one each cycle. It reads 0 in the cycle after an internal request is accepted. A pin reset and a disabled pin leave it counting.
- R4: The rising edge of each internal request sets that request's cause bit in the cycle after acceptance. Bits set earlier remain.
- R5: After an illegal-opcode, illegal-address or watchdog request is accepted, `pin_pull_o` and `irst_o` are high for exactly DRV_CYC cycles. `irst_o` then stays high alone for exactly HOLD_CYC more cycles.
- R6: After a low-voltage request is accepted, `irst_o` is high without `pin_pull_o` for STAB_CYC cycles. The DRV_CYC and HOLD_CYC phases follow.
- R7: The watchdog request is asynchronous. It is accepted on the third rising clock edge after it goes high, so `irst_o` is first seen high after that edge.
- R8: A request accepted while a sequence runs restarts it from the first phase for its cause, and its cause bit is ORed in.
- R9: When `pin_rst_en_i` is high, a pin sampled low (not caused by the block's own drive) raises `irst_o` from the next cycle. `irst_o` stays high while the pin is low, including past the end of an internal sequence. After the pin is released it stays high for HOLD_CYC more cycles.
- R10: The pin cause bit (bit1) is set only after the pin is sampled low on MIN_LOW_CYC (16) consecutive edges. A shorter low pulse still resets the chip but leaves bit1 clear.
- R11: When `pin_rst_en_i` is low, the pin level has no effect on `irst_o`, `status_o` or `sys_cnt_o`.
- R12: A `status_rd_i` strobe clears all cause bits at the next edge. A cause set on that same edge survives the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast sequencing clock |
| por_i | input | 1 | Power-on request, asynchronous, active high |
| cop_req_i | input | 1 | Watchdog timeout request, asynchronous to clk_i |
| lvi_req_i | input | 1 | Low-voltage request |
| ill_op_i | input | 1 | Illegal opcode request |
| ill_addr_i | input | 1 | Illegal address request |
| pin_level_i | input | 1 | Sampled level of the reset pin (1 = high) |
| pin_rst_en_i | input | 1 | Configuration: pin works as a reset input |
| monitor_i | input | 1 | Monitor mode active |
| status_rd_i | input | 1 | Read strobe of the cause register (clears it) |
| irst_o | output | 1 | Internal reset to the chip |
| pin_pull_o | output | 1 | Enable of the pin pull-down |
| status_o | output | 6 | Cause register |
| vec_hi_addr_o | output | 16 | Address of the vector high byte |
| vec_lo_addr_o | output | 16 | Address of the vector low byte |
| sys_cnt_o | output | 16 | Free-running system counter |

## Verification
A wrong phase state or phase count shows up as an internal reset or pin pull of the wrong length. The error is visible within one sequence, at the latest 4160 cycles after the request. A lost or stuck cause bit shows in `status_o` on the cycle after the request that should have changed it. A counter that is cleared or kept at the wrong time shows as a break in the one-per-cycle rise of `sys_cnt_o` on the very next cycle. A pin filter that counts the wrong samples shows as bit1 set after a short pulse, or left clear after a long one.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_STAB  = 3'd1,
        PH_DRIVE = 3'd2,
        PH_HOLD  = 3'd3,
        PH_EXT   = 3'd4
    } phase_e;

    localparam int ST_W    = 6;
    localparam int ST_POR  = 0;
    localparam int ST_PIN  = 1;
    localparam int ST_COP  = 2;
    localparam int ST_LVI  = 3;
    localparam int ST_ILOP = 4;
    localparam int ST_ILAD = 5;

endpackage

// File: rtl/rstseq_cop_sync.sv
module rstseq_cop_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic por_i,
    input  logic async_i,
    output logic rise_o
);
    // chain_q[STAGES] holds the previous synchronised value for edge detection
    logic [STAGES:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = async_i;
        for (int i = 1; i <= STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk_i or posedge por_i) begin
        if (por_i) chain_q <= '0;
        else       chain_q <= chain_d;
    end

    assign rise_o = chain_q[STAGES-1] & ~chain_q[STAGES];
endmodule

// File: rtl/rstseq_edge.sv
module rstseq_edge #(
    parameter int W = 3
) (
    input  logic         clk_i,
    input  logic         por_i,
    input  logic [W-1:0] req_i,
    output logic [W-1:0] rise_o
);
    logic [W-1:0] prev_d, prev_q;

    always_comb prev_d = req_i;

    always_ff @(posedge clk_i or posedge por_i) begin
        if (por_i) prev_q <= '0;
        else       prev_q <= prev_d;
    end

    assign rise_o = req_i & ~prev_q;
endmodule

// File: rtl/rstseq_pin_mon.sv
module rstseq_pin_mon #(
    parameter int MIN_LOW = 16
) (
    input  logic clk_i,
    input  logic por_i,
    input  logic pin_i,
    input  logic en_i,
    input  logic pull_i,
    output logic low_o,
    output logic long_o
);
    localparam int LW = $clog2(MIN_LOW + 1);
    localparam logic [LW-1:0] SAT  = LW'(MIN_LOW);
    localparam logic [LW-1:0] LAST = LW'(MIN_LOW - 1);

    logic [LW-1:0] cnt_d, cnt_q;

    // Low seen from outside only: the block's own pull-down is excluded
    assign low_o  = en_i & ~pin_i & ~pull_i;
    assign long_o = low_o & (cnt_q == LAST);

    always_comb begin
        if (!low_o)             cnt_d = '0;
        else if (cnt_q == SAT)  cnt_d = cnt_q;
        else                    cnt_d = cnt_q + LW'(1);
    end

    always_ff @(posedge clk_i or posedge por_i) begin
        if (por_i) cnt_q <= '0;
        else       cnt_q <= cnt_d;
    end
endmodule

// File: rtl/rstseq_ctrl.sv
module rstseq_ctrl
    import rstseq_pkg::*;
#(
    parameter int STAB_CYC = 4096,
    parameter int DRV_CYC  = 32,
    parameter int HOLD_CYC = 32,
    parameter int CNT_W    = 16
) (
    input  logic             clk_i,
    input  logic             por_i,
    input  logic [ST_W-1:0]  req_i,
    input  logic             pin_low_i,
    input  logic             pin_long_i,
    input  logic             status_rd_i,
    output logic             irst_o,
    output logic             pull_o,
    output logic [ST_W-1:0]  status_o,
    output logic [CNT_W-1:0] sys_cnt_o
);
    localparam int MAX_A = (STAB_CYC > DRV_CYC) ? STAB_CYC : DRV_CYC;
    localparam int MAXC  = (MAX_A > HOLD_CYC) ? MAX_A : HOLD_CYC;
    localparam int PW    = $clog2(MAXC + 1);
    localparam logic [PW-1:0] STAB_LAST = PW'(STAB_CYC - 1);
    localparam logic [PW-1:0] DRV_LAST  = PW'(DRV_CYC - 1);
    localparam logic [PW-1:0] HOLD_LAST = PW'(HOLD_CYC - 1);

    typedef struct packed {
        phase_e            ph;
        logic [PW-1:0]     cnt;
        logic [ST_W-1:0]   st;
        logic [CNT_W-1:0]  sys;
    } ctrl_t;

    localparam ctrl_t RST_VAL = '{ph: PH_STAB, cnt: '0,
                                  st: ST_W'(1 << ST_POR), sys: '0};

    ctrl_t d, q;
    logic [ST_W-1:0] set_v;
    logic int_any;

    assign int_any = req_i[ST_COP] | req_i[ST_LVI] | req_i[ST_ILOP] | req_i[ST_ILAD];

    always_comb begin
        d     = q;
        d.sys = q.sys + CNT_W'(1);

        set_v         = req_i;
        set_v[ST_POR] = 1'b0;
        set_v[ST_PIN] = pin_long_i;
        d.st = (status_rd_i ? '0 : q.st) | set_v;

        unique case (q.ph)
            PH_IDLE: begin
                if (pin_low_i) begin
                    d.ph  = PH_EXT;
                    d.cnt = '0;
                end
            end
            PH_STAB: begin
                if (q.cnt == STAB_LAST) begin
                    d.ph  = PH_DRIVE;
                    d.cnt = '0;
                end else begin
                    d.cnt = q.cnt + PW'(1);
                end
            end
            PH_DRIVE: begin
                if (q.cnt == DRV_LAST) begin
                    d.ph  = PH_HOLD;
                    d.cnt = '0;
                end else begin
                    d.cnt = q.cnt + PW'(1);
                end
            end
            PH_HOLD: begin
                if (pin_low_i) begin
                    d.ph  = PH_EXT;
                    d.cnt = '0;
                end else if (q.cnt == HOLD_LAST) begin
                    d.ph  = PH_IDLE;
                    d.cnt = '0;
                end else begin
                    d.cnt = q.cnt + PW'(1);
                end
            end
            PH_EXT: begin
                if (!pin_low_i) begin
                    d.ph  = PH_HOLD;
                    d.cnt = '0;
                end
            end
            default: begin
                d.ph  = PH_IDLE;
                d.cnt = '0;
            end
        endcase

        // Any internal cause restarts the sequence and clears the shared counter
        if (int_any) begin
            d.sys = '0;
            d.cnt = '0;
            d.ph  = req_i[ST_LVI] ? PH_STAB : PH_DRIVE;
        end
    end

    always_ff @(posedge clk_i or posedge por_i) begin
        if (por_i) q <= RST_VAL;
        else       q <= d;
    end

    assign irst_o    = (q.ph != PH_IDLE);
    assign pull_o    = (q.ph == PH_DRIVE);
    assign status_o  = q.st;
    assign sys_cnt_o = q.sys;
endmodule

// File: rtl/reset_sequencer.sv
module reset_sequencer
    import rstseq_pkg::*;
#(
    parameter int          STAB_CYC    = 4096,
    parameter int          DRV_CYC     = 32,
    parameter int          HOLD_CYC    = 32,
    parameter int          MIN_LOW_CYC = 16,
    parameter int          SYNC_STAGES = 2,
    parameter int          CNT_W       = 16,
    parameter logic [15:0] VEC_NORMAL  = 16'hFFFE,
    parameter logic [15:0] VEC_MONITOR = 16'hFEFE
) (
    input  logic             clk_i,
    input  logic             por_i,
    input  logic             cop_req_i,
    input  logic             lvi_req_i,
    input  logic             ill_op_i,
    input  logic             ill_addr_i,
    input  logic             pin_level_i,
    input  logic             pin_rst_en_i,
    input  logic             monitor_i,
    input  logic             status_rd_i,
    output logic             irst_o,
    output logic             pin_pull_o,
    output logic [5:0]       status_o,
    output logic [15:0]      vec_hi_addr_o,
    output logic [15:0]      vec_lo_addr_o,
    output logic [CNT_W-1:0] sys_cnt_o
);
    logic [2:0]      sync_rise;
    logic            cop_rise;
    logic            pin_low, pin_long;
    logic [ST_W-1:0] req_vec;

    rstseq_edge #(.W(3)) u_edge (
        .clk_i  (clk_i),
        .por_i  (por_i),
        .req_i  ({ill_addr_i, ill_op_i, lvi_req_i}),
        .rise_o (sync_rise)
    );

    rstseq_cop_sync #(.STAGES(SYNC_STAGES)) u_cop (
        .clk_i   (clk_i),
        .por_i   (por_i),
        .async_i (cop_req_i),
        .rise_o  (cop_rise)
    );

    rstseq_pin_mon #(.MIN_LOW(MIN_LOW_CYC)) u_pin (
        .clk_i  (clk_i),
        .por_i  (por_i),
        .pin_i  (pin_level_i),
        .en_i   (pin_rst_en_i),
        .pull_i (pin_pull_o),
        .low_o  (pin_low),
        .long_o (pin_long)
    );

    always_comb begin
        req_vec          = '0;
        req_vec[ST_COP]  = cop_rise;
        req_vec[ST_LVI]  = sync_rise[0];
        req_vec[ST_ILOP] = sync_rise[1];
        req_vec[ST_ILAD] = sync_rise[2];
    end

    rstseq_ctrl #(
        .STAB_CYC (STAB_CYC),
        .DRV_CYC  (DRV_CYC),
        .HOLD_CYC (HOLD_CYC),
        .CNT_W    (CNT_W)
    ) u_ctrl (
        .clk_i       (clk_i),
        .por_i       (por_i),
        .req_i       (req_vec),
        .pin_low_i   (pin_low),
        .pin_long_i  (pin_long),
        .status_rd_i (status_rd_i),
        .irst_o      (irst_o),
        .pull_o      (pin_pull_o),
        .status_o    (status_o),
        .sys_cnt_o   (sys_cnt_o)
    );

    assign vec_hi_addr_o = monitor_i ? VEC_MONITOR : VEC_NORMAL;
    assign vec_lo_addr_o = vec_hi_addr_o + 16'd1;
endmodule

// File: rtl/rstseq_chk.sv
module rstseq_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk_i,
    input logic             por_i,
    input logic             lvi_req_i,
    input logic             ill_op_i,
    input logic             ill_addr_i,
    input logic             irst_o,
    input logic             pin_pull_o,
    input logic [5:0]       status_o,
    input logic [CNT_W-1:0] sys_cnt_o
);
    AST_PULL_UNDER_IRST: assert property (@(posedge clk_i) disable iff (por_i)
        pin_pull_o |-> irst_o);                                          // R5
    AST_HOLD_AFTER_PULL: assert property (@(posedge clk_i) disable iff (por_i)
        $fell(pin_pull_o) |-> irst_o);                                   // R5
    AST_ILOP_CAUSE: assert property (@(posedge clk_i) disable iff (por_i)
        $rose(ill_op_i) |=> status_o[4]);                                // R4
    AST_ILAD_DRIVE: assert property (@(posedge clk_i) disable iff (por_i)
        ($rose(ill_addr_i) && !$rose(lvi_req_i)) |=> pin_pull_o);        // R5
    AST_LVI_STAB: assert property (@(posedge clk_i) disable iff (por_i)
        $rose(lvi_req_i) |=> (irst_o && !pin_pull_o));                   // R6
    AST_CNT_CLEAR: assert property (@(posedge clk_i) disable iff (por_i)
        $rose(ill_op_i) |=> (sys_cnt_o == '0));                          // R3
endmodule

bind reset_sequencer rstseq_chk #(.CNT_W(CNT_W)) u_chk (
    .clk_i      (clk_i),
    .por_i      (por_i),
    .lvi_req_i  (lvi_req_i),
    .ill_op_i   (ill_op_i),
    .ill_addr_i (ill_addr_i),
    .irst_o     (irst_o),
    .pin_pull_o (pin_pull_o),
    .status_o   (status_o),
    .sys_cnt_o  (sys_cnt_o)
);

// File: tb/reset_sequencer_bench.sv
module reset_sequencer_bench;
    logic clk = 1'b0;
    logic por = 1'b1, cop = 1'b0, lvi = 1'b0, ilop = 1'b0, ilad = 1'b0;
    logic cfg_en = 1'b0, mon = 1'b0, rd = 1'b0, ext_low = 1'b0;
    logic pin_lvl, irst, pull;
    logic [5:0]  status;
    logic [15:0] vhi, vlo, cnt;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    always #2 clk = ~clk;   // 250 MHz

    assign pin_lvl = ~(pull | ext_low);

    reset_sequencer u_reset_sequencer (
        .clk_i(clk), .por_i(por), .cop_req_i(cop), .lvi_req_i(lvi),
        .ill_op_i(ilop), .ill_addr_i(ilad), .pin_level_i(pin_lvl),
        .pin_rst_en_i(cfg_en), .monitor_i(mon), .status_rd_i(rd),
        .irst_o(irst), .pin_pull_o(pull), .status_o(status),
        .vec_hi_addr_o(vhi), .vec_lo_addr_o(vlo), .sys_cnt_o(cnt)
    );

    typedef struct packed {
        logic [1:0]  src;    // 0 ilop, 1 ilad, 2 cop, 3 lvi
        logic        mon;
        logic [5:0]  sbit;
        logic [12:0] stab;
    } case_t;

    localparam case_t CASES [4] = '{
        '{src: 2'd0, mon: 1'b0, sbit: 6'b010000, stab: 13'd0},
        '{src: 2'd1, mon: 1'b1, sbit: 6'b100000, stab: 13'd0},
        '{src: 2'd2, mon: 1'b0, sbit: 6'b000100, stab: 13'd0},
        '{src: 2'd3, mon: 1'b1, sbit: 6'b001000, stab: 13'd4096}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Samples at each falling edge until irst falls; counts phase lengths
    task automatic measure(output int s, output int dv, output int h, output logic [15:0] c0);
        s = 0; dv = 0; h = 0; c0 = cnt;
        for (int i = 0; i < 10000; i++) begin
            if (!irst) break;
            if (pull)           dv++;
            else if (dv == 0)   s++;
            else                h++;
            @(negedge clk);
        end
    endtask

    task automatic pulse_rd();
        rd = 1'b1; @(negedge clk); rd = 1'b0;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                errors++; checks++;
                $display("FAIL watchdog: actual=%0d expected<150000", cycles);
                $display("Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        end
    end

    initial begin
        int s, dv, h;
        logic [15:0] c0, a;
        repeat (3) @(negedge clk);
        chk("R1 status during por", 32'(status), 32'h01);
        chk("R1 irst during por", 32'(irst), 32'h1);
        chk("R1 no pull during por", 32'(pull), 32'h0);
        chk("R1 counter during por", 32'(cnt), 32'h0);
        por = 1'b0;
        measure(s, dv, h, c0);
        chk("R1 stab length", 32'(s), 32'd4096);
        chk("R1 drive length", 32'(dv), 32'd32);
        chk("R1 hold length", 32'(h), 32'd32);

        // Table walk: one internal cause per entry
        for (int i = 0; i < 4; i++) begin
            mon = CASES[i].mon;
            pulse_rd();
            unique case (CASES[i].src)
                2'd0: ilop = 1'b1;
                2'd1: ilad = 1'b1;
                2'd2: cop  = 1'b1;
                default: lvi = 1'b1;
            endcase
            @(negedge clk);
            if (CASES[i].src == 2'd2) begin
                chk("R7 cop not yet after one edge", 32'(irst), 32'h0);
                @(negedge clk);
                chk("R7 cop not yet after two edges", 32'(irst), 32'h0);
                @(negedge clk);
            end
            ilop = 1'b0; ilad = 1'b0; cop = 1'b0; lvi = 1'b0;
            measure(s, dv, h, c0);
            chk("R6 R5 stab phase", 32'(s), 32'(CASES[i].stab));
            chk("R5 drive phase", 32'(dv), 32'd32);
            chk("R5 hold phase", 32'(h), 32'd32);
            chk("R3 counter cleared", 32'(c0), 32'h0);
            chk("R4 cause bit", 32'(status), 32'(CASES[i].sbit));
            chk("R2 vector high", 32'(vhi), CASES[i].mon ? 32'hFEFE : 32'hFFFE);
            chk("R2 vector low", 32'(vlo), CASES[i].mon ? 32'hFEFF : 32'hFFFF);
        end
        mon = 1'b0;

        // R8: restart by a second cause in the middle of the drive phase
        pulse_rd();
        ilop = 1'b1; @(negedge clk); ilop = 1'b0;
        repeat (10) @(negedge clk);
        ilad = 1'b1; @(negedge clk); ilad = 1'b0;
        measure(s, dv, h, c0);
        chk("R8 drive restarted", 32'(dv), 32'd32);
        chk("R8 hold after restart", 32'(h), 32'd32);
        chk("R8 both causes kept", 32'(status), 32'h30);

        // R12: read clears; same-edge cause survives
        rd = 1'b1; ilop = 1'b1; @(negedge clk); rd = 1'b0; ilop = 1'b0;
        chk("R12 same-edge cause survives", 32'(status), 32'h10);
        measure(s, dv, h, c0);
        pulse_rd();
        chk("R12 read clears", 32'(status), 32'h0);

        // R11: pin ignored while disabled
        cfg_en = 1'b0;
        a = cnt;
        ext_low = 1'b1;
        repeat (20) @(negedge clk);
        chk("R11 no reset when disabled", 32'(irst), 32'h0);
        chk("R11 no cause when disabled", 32'(status), 32'h0);
        chk("R11 counter keeps running", 32'(cnt), 32'(16'(a + 16'd20)));
        ext_low = 1'b0;
        @(negedge clk);

        // R9 R10: short pin pulse
        cfg_en = 1'b1;
        a = cnt;
        ext_low = 1'b1;
        @(negedge clk);
        chk("R9 pin reset asserts", 32'(irst), 32'h1);
        repeat (4) @(negedge clk);
        ext_low = 1'b0;
        measure(s, dv, h, c0);
        chk("R9 release plus hold", 32'(s), 32'd33);
        chk("R10 short pulse no cause", 32'(status), 32'h0);
        chk("R3 pin reset keeps counter", 32'(cnt), 32'(16'(a + 16'(5 + s + dv + h))));

        // R10: long pin pulse sets the pin cause
        ext_low = 1'b1;
        repeat (20) @(negedge clk);
        ext_low = 1'b0;
        chk("R10 long pulse cause", 32'(status), 32'h02);
        measure(s, dv, h, c0);

        // R9: pin held low past the end of an internal sequence
        pulse_rd();
        ilop = 1'b1; @(negedge clk); ilop = 1'b0;
        repeat (40) @(negedge clk);
        ext_low = 1'b1;
        repeat (60) @(negedge clk);
        chk("R9 reset held by low pin", 32'(irst), 32'h1);
        ext_low = 1'b0;
        measure(s, dv, h, c0);
        chk("R9 hold after pin release", 32'(s), 32'd33);
        cfg_en = 1'b0;

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule